// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell Array

This block is a row of programmable output cells of the kind found in small programmable logic parts. Every cell sums a set of programmable product terms taken over one shared literal bus. That bus carries the external input bus and one feedback bit from each cell. The sum can reach the cell's pin directly, or through a D flip-flop clocked by the shared clock. The pin itself is modelled as a data value plus a drive enable, which together stand for a tri-state driver.

Static configuration vectors set four things:
- which literals each product term uses, in true or complement form;
- whether each cell's output is registered or combinational;
- whether each cell's feedback comes from its register or from its pin;
- the polarity of the pin data and of the drive enable.

All flip-flops share an asynchronous clear to 0 and a synchronous preset to 1. The clear takes priority over the preset.

Top module: `pal_mc_array`

## Requirements
- R1: The literal bus has N_IN+N_CELL bits. Literal j < N_IN is `in_bus[j]`, and literal N_IN+c is the feedback bit of cell c. Bit ((c*N_TERM+t)*(N_IN+N_CELL)+j) of `term_true` (or `term_comp`) enables literal j in true (or complemented) form in term t of cell c. A term is 1 when every enabled true literal is 1 and every enabled complemented literal is 0. A cell's sum is the OR of its N_TERM terms.
- R2: A term with no enabled literal evaluates to 1. A term that enables the same literal in both true and complemented form evaluates to 0.
- R3: While `arst` is high, every cell register reads 0 at once, without waiting for a clock edge.
- R4: With `arst` low and `preset` high at a rising clock edge, every register becomes 1. If `arst` is also high, the registers stay at 0.
- R5: With neither `arst` nor `preset` active, each register loads its cell's sum on the rising clock edge.
- R6: When `out_reg[c]` is 1, the pin value of cell c is its register. When it is 0, the pin value is the combinational sum.
- R7: `pin_data[c]` is the pin value XORed with `out_inv[c]`.
- R8: `pin_en[c]` is `oe[c]` XORed with `oe_inv[c]`. When `pin_en[c]` is 0, the pin is at high impedance and `pin_data[c]` is not driven.
- R9: When `fb_pin[c]` is 0, the feedback of cell c is its register. When `fb_pin[c]` is 1 and the output is registered, the feedback is the driven pin data, with polarity applied. When `fb_pin[c]` is 1 and the output is combinational, the feedback is the external pad value `pad_in[c]`, so the cell serves as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cell registers |
| arst | input | 1 | Asynchronous clear of all registers, active high |
| preset | input | 1 | Synchronous preset of all registers, active high |
| in_bus | input | N_IN | Shared input literals |
| pad_in | input | N_CELL | Pad value sampled as feedback for combinational cells with pin feedback |
| oe | input | N_CELL | Per-cell output enable before polarity |
| term_true | input | N_CELL*N_TERM*(N_IN+N_CELL) | True-literal masks |
| term_comp | input | N_CELL*N_TERM*(N_IN+N_CELL) | Complement-literal masks |
| out_reg | input | N_CELL | 1 = registered output, 0 = combinational |
| fb_pin | input | N_CELL | 1 = pin feedback, 0 = register feedback |
| out_inv | input | N_CELL | Inverts the pin data |
| oe_inv | input | N_CELL | Inverts the drive enable |
| pin_data | output | N_CELL | Driver data per cell |
| pin_en | output | N_CELL | Driver enable per cell (0 = high impedance) |

## Verification
The bench targets the degenerate product terms first. An empty term must give 1 and a contradictory term must give 0. A design that ignored the complement mask, or treated an empty term as 0, would flip the pin.

It then asserts the clear in mid-cycle after a register has been set. A clear implemented synchronously would leave the pin high until the next edge. The bench also raises clear and preset together to catch a reversed priority.

Finally, a cell whose single term is the complement of its own feedback should toggle on every edge. A second cell reads the first cell's feedback under each feedback selection. Any swap of the feedback mux inputs, a missing polarity on the feedback, or a wrong mask index then shows up on the second cell's pin.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

    // Static per-cell options
    typedef struct packed {
        logic out_reg;   // 1: pin follows the register
        logic fb_pin;    // 1: feedback taken from the pin side
        logic out_inv;   // data polarity
        logic oe_inv;    // enable polarity
    } cell_cfg_t;

    // Modelled tri-state driver
    typedef struct packed {
        logic data;
        logic en;
    } pin_drv_t;

    // One product term: each enabled literal must match its polarity
    function automatic logic term_hit(input logic lit_val, input logic use_true,
                                      input logic use_comp);
        return (lit_val | ~use_true) & (~lit_val | ~use_comp);
    endfunction

endpackage

// File: rtl/pal_pterm_sum.sv
module pal_pterm_sum
    import pal_mc_pkg::*;
#(
    parameter int N_LIT  = 12,
    parameter int N_TERM = 8
) (
    input  logic [N_LIT-1:0]        lits,
    input  logic [N_TERM*N_LIT-1:0] tmask,
    input  logic [N_TERM*N_LIT-1:0] cmask,
    output logic                    sum
);
    localparam int MW = N_TERM * N_LIT;

    logic [N_TERM-1:0] term;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_LIT-1:0] hit;
        for (genvar j = 0; j < N_LIT; j++) begin : g_lit
            assign hit[j] = term_hit(lits[j], tmask[t*N_LIT+j], cmask[t*N_LIT+j]);
        end
        assign term[t] = &hit;
    end

    assign sum = |term;

    logic unused_w;
    assign unused_w = (MW == 0);
endmodule

// File: rtl/pal_mc_cell.sv
module pal_mc_cell
    import pal_mc_pkg::*;
(
    input  logic      clk,
    input  logic      arst,
    input  logic      preset,
    input  logic      sum,
    input  logic      oe,
    input  logic      pad,
    input  cell_cfg_t cfg,
    output logic      q,
    output logic      fb,
    output pin_drv_t  pin
);
    logic pin_val;
    logic reg_pin;

    // Clear is asynchronous and wins; preset is synchronous
    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            q <= 1'b0;
        else if (preset)
            q <= 1'b1;
        else
            q <= sum;
    end

    always_comb begin
        reg_pin  = q ^ cfg.out_inv;
        pin_val  = cfg.out_reg ? q : sum;
        pin.data = pin_val ^ cfg.out_inv;
        pin.en   = oe ^ cfg.oe_inv;
        // Pin feedback never passes through the sum, so no loop exists
        if (!cfg.fb_pin)
            fb = q;
        else if (cfg.out_reg)
            fb = reg_pin;
        else
            fb = pad;
    end
endmodule

// File: rtl/pal_mc_array.sv
module pal_mc_array
    import pal_mc_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_CELL = 4,
    parameter int N_TERM = 8
) (
    input  logic                                   clk,
    input  logic                                   arst,
    input  logic                                   preset,
    input  logic [N_IN-1:0]                        in_bus,
    input  logic [N_CELL-1:0]                      pad_in,
    input  logic [N_CELL-1:0]                      oe,
    input  logic [N_CELL*N_TERM*(N_IN+N_CELL)-1:0] term_true,
    input  logic [N_CELL*N_TERM*(N_IN+N_CELL)-1:0] term_comp,
    input  logic [N_CELL-1:0]                      out_reg,
    input  logic [N_CELL-1:0]                      fb_pin,
    input  logic [N_CELL-1:0]                      out_inv,
    input  logic [N_CELL-1:0]                      oe_inv,
    output logic [N_CELL-1:0]                      pin_data,
    output logic [N_CELL-1:0]                      pin_en
);
    localparam int N_LIT  = N_IN + N_CELL;
    localparam int CELL_W = N_TERM * N_LIT;

    logic [N_CELL-1:0] fb_vec;
    logic [N_CELL-1:0] sum_vec;
    logic [N_CELL-1:0] reg_q;
    logic [N_LIT-1:0]  lits;

    assign lits = {fb_vec, in_bus};

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        cell_cfg_t cfg;
        pin_drv_t  drv;

        assign cfg = '{out_reg: out_reg[c], fb_pin: fb_pin[c],
                       out_inv: out_inv[c], oe_inv: oe_inv[c]};

        pal_pterm_sum #(.N_LIT(N_LIT), .N_TERM(N_TERM)) u_sum (
            .lits  (lits),
            .tmask (term_true[c*CELL_W +: CELL_W]),
            .cmask (term_comp[c*CELL_W +: CELL_W]),
            .sum   (sum_vec[c])
        );

        pal_mc_cell u_cell (
            .clk    (clk),
            .arst   (arst),
            .preset (preset),
            .sum    (sum_vec[c]),
            .oe     (oe[c]),
            .pad    (pad_in[c]),
            .cfg    (cfg),
            .q      (reg_q[c]),
            .fb     (fb_vec[c]),
            .pin    (drv)
        );

        assign pin_data[c] = drv.data;
        assign pin_en[c]   = drv.en;
    end
endmodule

// File: rtl/pal_mc_array_chk.sv
module pal_mc_array_chk #(
    parameter int N_CELL = 4
) (
    input logic              clk,
    input logic              arst,
    input logic              preset,
    input logic [N_CELL-1:0] reg_q,
    input logic [N_CELL-1:0] sum_vec,
    input logic [N_CELL-1:0] oe,
    input logic [N_CELL-1:0] oe_inv,
    input logic [N_CELL-1:0] out_reg,
    input logic [N_CELL-1:0] out_inv,
    input logic [N_CELL-1:0] pin_data,
    input logic [N_CELL-1:0] pin_en
);
    // R3: registers read zero while clear is held
    a_r3_clear_zero: assert property (@(posedge clk) arst |-> (reg_q == '0));

    // R4: preset fills every register on the next edge
    a_r4_preset_ones: assert property (@(posedge clk) disable iff (arst)
        preset |=> (reg_q == '1));

    // R5: registers load the sums when idle
    a_r5_load_sum: assert property (@(posedge clk) disable iff (arst)
        !preset |=> (reg_q == $past(sum_vec)));

    // R6, R7: a registered, non-inverted cell drives its register value
    a_r6_reg_path: assert property (@(posedge clk) disable iff (arst)
        (out_reg == '1 && out_inv == '0) |-> (pin_data == reg_q));

    // R8: enable polarity
    a_r8_enable: assert property (@(posedge clk) disable iff (arst)
        pin_en == (oe ^ oe_inv));
endmodule

bind pal_mc_array pal_mc_array_chk #(.N_CELL(N_CELL)) u_chk (
    .clk      (clk),
    .arst     (arst),
    .preset   (preset),
    .reg_q    (reg_q),
    .sum_vec  (sum_vec),
    .oe       (oe),
    .oe_inv   (oe_inv),
    .out_reg  (out_reg),
    .out_inv  (out_inv),
    .pin_data (pin_data),
    .pin_en   (pin_en)
);

// File: tb/pal_mc_array_tb.sv
`timescale 1ns/1ps
module pal_mc_array_tb;
    localparam int NI = 8;
    localparam int NC = 4;
    localparam int NT = 8;
    localparam int NL = NI + NC;
    localparam int MW = NC * NT * NL;

    logic          clk = 1'b0;
    logic          arst, preset;
    logic [NI-1:0] in_bus;
    logic [NC-1:0] pad_in, oe, out_reg, fb_pin, out_inv, oe_inv;
    logic [MW-1:0] tm, cm;
    logic [NC-1:0] pin_data, pin_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pal_mc_array #(.N_IN(NI), .N_CELL(NC), .N_TERM(NT)) u_dut (
        .clk(clk), .arst(arst), .preset(preset), .in_bus(in_bus),
        .pad_in(pad_in), .oe(oe), .term_true(tm), .term_comp(cm),
        .out_reg(out_reg), .fb_pin(fb_pin), .out_inv(out_inv),
        .oe_inv(oe_inv), .pin_data(pin_data), .pin_en(pin_en)
    );

    function automatic int bi(int c, int t, int j);
        return (c * NT + t) * NL + j;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Every term of every cell contradicts itself: all sums 0
    task automatic kill_all();
        tm = '0;
        cm = '0;
        for (int c = 0; c < NC; c++)
            for (int t = 0; t < NT; t++) begin
                tm[bi(c, t, 0)] = 1'b1;
                cm[bi(c, t, 0)] = 1'b1;
            end
    endtask

    task automatic clear_term(int c, int t);
        for (int j = 0; j < NL; j++) begin
            tm[bi(c, t, j)] = 1'b0;
            cm[bi(c, t, j)] = 1'b0;
        end
    endtask

    // Rising edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic t_reset();
        arst = 1'b1; preset = 1'b0; in_bus = '0; pad_in = '0; oe = '1;
        out_reg = '1; fb_pin = '0; out_inv = '0; oe_inv = '0;
        kill_all();
        #5;
        chk("R3 reset state cell0", pin_data[0], 1'b0);
        chk("R3 reset state cell3", pin_data[3], 1'b0);
        tick();
        arst = 1'b0;
        #2;
    endtask

    task automatic t_degenerate();
        out_reg = '0;
        kill_all();
        #1 chk("R2 contradictory terms give 0", pin_data[0], 1'b0);
        clear_term(0, 5);
        #1 chk("R2 empty term gives 1", pin_data[0], 1'b1);
        tm[bi(0, 5, 3)] = 1'b1;
        cm[bi(0, 5, 3)] = 1'b1;
        in_bus = 8'h08;
        #1 chk("R2 both masks on literal 3 gives 0", pin_data[0], 1'b0);
    endtask

    task automatic t_sop();
        out_reg = '0;
        kill_all();
        clear_term(0, 0);
        tm[bi(0, 0, 0)] = 1'b1;   // in0
        cm[bi(0, 0, 1)] = 1'b1;   // ~in1
        clear_term(0, 6);
        tm[bi(0, 6, 2)] = 1'b1;   // in2
        tm[bi(0, 6, 7)] = 1'b1;   // in7
        in_bus = 8'b0000_0001;
        #1 chk("R1 in0 & ~in1 true", pin_data[0], 1'b1);
        in_bus = 8'b0000_0011;
        #1 chk("R1 in1 set blocks term", pin_data[0], 1'b0);
        in_bus = 8'b1000_0110;
        #1 chk("R1 second term in2&in7", pin_data[0], 1'b1);
        in_bus = 8'b0000_0110;
        #1 chk("R1 in7 missing", pin_data[0], 1'b0);
        chk("R1 other cell unaffected", pin_data[1], 1'b0);
    endtask

    task automatic t_register();
        out_reg = '0;
        out_reg[0] = 1'b1;
        kill_all();
        clear_term(0, 0);
        tm[bi(0, 0, 4)] = 1'b1;
        in_bus = 8'h10;
        #1 chk("R6 registered pin holds old value", pin_data[0], 1'b0);
        tick();
        chk("R5 register loads sum 1", pin_data[0], 1'b1);
        in_bus = 8'h00;
        #1 chk("R6 registered pin ignores sum change", pin_data[0], 1'b1);
        tick();
        chk("R5 register loads sum 0", pin_data[0], 1'b0);
    endtask

    task automatic t_preset_clear();
        out_reg = '1;
        kill_all();
        preset = 1'b1;
        tick();
        preset = 1'b0;
        chk("R4 preset sets cell0", pin_data[0], 1'b1);
        chk("R4 preset sets cell2", pin_data[2], 1'b1);
        #4 arst = 1'b1;
        #1 chk("R3 clear acts before next edge", pin_data[2], 1'b0);
        preset = 1'b1;
        tick();
        chk("R4 clear wins over preset", pin_data[1], 1'b0);
        preset = 1'b0;
        arst = 1'b0;
        tick();
    endtask

    task automatic t_driver();
        out_reg = '0;
        kill_all();
        clear_term(1, 0);                 // cell1 sum = 1
        oe = 4'b0010; oe_inv = '0; out_inv = '0;
        #1 chk("R8 enable plain on", pin_en[1], 1'b1);
        chk("R8 enable plain off", pin_en[0], 1'b0);
        chk("R7 data plain", pin_data[1], 1'b1);
        oe_inv = 4'b0011; out_inv = 4'b0010;
        #1 chk("R8 inverted enable high-Z", pin_en[1], 1'b0);
        chk("R8 inverted enable on", pin_en[0], 1'b1);
        chk("R7 inverted data", pin_data[1], 1'b0);
        oe_inv = '0; out_inv = '0; oe = '1;
    endtask

    task automatic t_feedback();
        kill_all();
        out_reg = 4'b0001; fb_pin = '0; out_inv = '0;
        // cell0 term0 = ~fb0 : toggle
        clear_term(0, 0);
        cm[bi(0, 0, NI + 0)] = 1'b1;
        // cell1 term0 = fb0
        clear_term(1, 0);
        tm[bi(1, 0, NI + 0)] = 1'b1;
        arst = 1'b1;
        #2 arst = 1'b0;
        #1 chk("R9 register feedback 0 seen by cell1", pin_data[1], 1'b0);
        tick();
        chk("R9 toggle via own feedback to 1", pin_data[0], 1'b1);
        chk("R9 register feedback 1 seen by cell1", pin_data[1], 1'b1);
        tick();
        chk("R9 toggle back to 0", pin_data[0], 1'b0);
        fb_pin[0] = 1'b1; out_inv[0] = 1'b1;
        #1 chk("R9 pin feedback carries inverted data", pin_data[1], 1'b1);
        out_reg[0] = 1'b0; pad_in[0] = 1'b0;
        #1 chk("R9 combinational pin feedback uses pad 0", pin_data[1], 1'b0);
        pad_in[0] = 1'b1;
        #1 chk("R9 combinational pin feedback uses pad 1", pin_data[1], 1'b1);
        fb_pin[0] = 1'b0;
        #1 chk("R9 register feedback restored", pin_data[1], 1'b0);
        out_inv = '0; out_reg = '1;
    endtask

    initial begin
        t_reset();
        t_degenerate();
        t_sop();
        t_register();
        t_preset_clear();
        t_driver();
        t_feedback();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule